// File: doc/BRIEF.md
# I2C Byte Event and Request Selector

This block sits next to a nine-clock I2C shift engine (eight data bits followed by the acknowledge slot) and converts bit-level bus timing into request pulses in the system clock domain. The engine supplies single-cycle strobes for the rising and falling edges of SCL, its current bit position, and the SDA value. The block produces a transmit-side interrupt pulse, a receive-side interrupt pulse, a DMA request pulse and a load strobe that copies the receive shift register into the receive buffer.

A mode select input picks which bus events raise the interrupts. In acknowledge mode (select low), the rising SCL edge of the acknowledge slot samples SDA. An ACK raises the receive-side interrupt and a NACK raises the transmit-side interrupt. In edge mode (select high), the rising SCL edge of the last bit raises the transmit-side interrupt and its falling edge raises the receive-side interrupt. In both modes the DMA request tracks the receive-side source, and the buffer load always follows the rising edge of the last bit. The shift engine clears its bit position when it detects a start condition. Every output is registered, so it appears one clock after the strobe that causes it.

Top module: `i2cByteEvents`

## Requirements
- R1: While reset is asserted and in the first cycle after it, txIrq, rxIrq, dmaReq and rxLoad are all 0.
- R2: One clock after sclRise is high with bitCount equal to 9 (the acknowledge slot), rxLoad is 1 for exactly one cycle, in both modes.
- R3: With modeSel=0, a sclRise at bitCount 9 with sdaIn=0 (ACK) gives rxIrq=1 one clock later, and txIrq stays 0.
- R4: With modeSel=0, a sclRise at bitCount 9 with sdaIn=1 (NACK) gives txIrq=1 one clock later, and rxIrq stays 0.
- R5: With modeSel=1, a sclRise at bitCount 9 gives txIrq=1 one clock later, whatever the value of sdaIn, and rxIrq stays 0.
- R6: With modeSel=1, a sclFall at bitCount 9 gives rxIrq=1 one clock later, and txIrq and rxLoad stay 0.
- R7: dmaReq equals rxIrq in every cycle.
- R8: SCL edges at any bitCount other than 9, and cycles with no SCL edge, leave all four outputs at 0 one clock later.
- R9: With modeSel=0, a sclFall at bitCount 9 raises no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sclRise | input | 1 | Single-cycle strobe on a rising SCL edge |
| sclFall | input | 1 | Single-cycle strobe on a falling SCL edge |
| bitCount | input | 4 | Current bit position, 1 to 9, where 9 is the acknowledge slot; 0 after a start condition |
| sdaIn | input | 1 | SDA value, sampled with sclRise (0 means ACK) |
| modeSel | input | 1 | 0 selects acknowledge mode, 1 selects edge mode |
| txIrq | output | 1 | Transmit-side interrupt pulse |
| rxIrq | output | 1 | Receive-side interrupt pulse |
| dmaReq | output | 1 | DMA request pulse |
| rxLoad | output | 1 | Receive buffer load strobe |

## Verification
The hardest situation to reach is the mode select changing between the rising and falling edges of the same acknowledge slot. The two edges of one slot are then decoded under different modes, so a single slot can raise the receive load, then one interrupt, then none or the other. Random stimulus draws the mode on every cycle and weights the bit position towards the acknowledge slot, so these mixed slots occur often. Directed cases add an acknowledge-mode falling edge and an edge-mode NACK.

// File: rtl/i2cEvtPkg.sv
package i2cEvtPkg;
  typedef struct packed {
    logic lastRise;
    logic lastFall;
    logic ackSeen;
    logic nackSeen;
  } evtStrobes_t;
endpackage

// File: rtl/i2cEvtCtrl.sv
module i2cEvtCtrl
  import i2cEvtPkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int COUNT_W = $clog2(DATA_BITS + 2)
) (
  input  logic               sclRise,
  input  logic               sclFall,
  input  logic [COUNT_W-1:0] bitCount,
  input  logic               sdaIn,
  output evtStrobes_t        strobes
);
  localparam int LAST_BIT = DATA_BITS + 1;

  logic onLast;

  always_comb begin
    onLast = (bitCount == COUNT_W'(LAST_BIT));
    strobes.lastRise = onLast && sclRise;
    strobes.lastFall = onLast && sclFall;
    strobes.ackSeen  = onLast && sclRise && !sdaIn;
    strobes.nackSeen = onLast && sclRise && sdaIn;
  end
endmodule

// File: rtl/i2cEvtPath.sv
module i2cEvtPath
  import i2cEvtPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        modeSel,
  input  evtStrobes_t strobes,
  output logic        txIrq,
  output logic        rxIrq,
  output logic        dmaReq,
  output logic        rxLoad
);
  logic txNext, rxNext;

  always_comb begin
    if (modeSel) begin
      txNext = strobes.lastRise;
      rxNext = strobes.lastFall;
    end else begin
      txNext = strobes.nackSeen;
      rxNext = strobes.ackSeen;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txIrq  <= 1'b0;
      rxIrq  <= 1'b0;
      dmaReq <= 1'b0;
      rxLoad <= 1'b0;
    end else begin
      txIrq  <= txNext;
      rxIrq  <= rxNext;
      dmaReq <= rxNext;
      rxLoad <= strobes.lastRise;
    end
  end
endmodule

// File: rtl/i2cByteEvents.sv
module i2cByteEvents
  import i2cEvtPkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int COUNT_W = $clog2(DATA_BITS + 2)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclRise,
  input  logic               sclFall,
  input  logic [COUNT_W-1:0] bitCount,
  input  logic               sdaIn,
  input  logic               modeSel,
  output logic               txIrq,
  output logic               rxIrq,
  output logic               dmaReq,
  output logic               rxLoad
);
  evtStrobes_t strobes;

  i2cEvtCtrl #(.DATA_BITS(DATA_BITS), .COUNT_W(COUNT_W)) uCtrl (
    .sclRise(sclRise), .sclFall(sclFall), .bitCount(bitCount),
    .sdaIn(sdaIn), .strobes(strobes)
  );

  i2cEvtPath uPath (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .strobes(strobes),
    .txIrq(txIrq), .rxIrq(rxIrq), .dmaReq(dmaReq), .rxLoad(rxLoad)
  );
endmodule

// File: rtl/i2cByteEventsChk.sv
module i2cByteEventsChk #(
  parameter int DATA_BITS = 8,
  parameter int COUNT_W = $clog2(DATA_BITS + 2)
) (
  input logic               clk,
  input logic               rstN,
  input logic               sclRise,
  input logic               sclFall,
  input logic [COUNT_W-1:0] bitCount,
  input logic               sdaIn,
  input logic               modeSel,
  input logic               txIrq,
  input logic               rxIrq,
  input logic               dmaReq,
  input logic               rxLoad
);
  localparam int LAST_BIT = DATA_BITS + 1;
  logic onLast;
  assign onLast = (bitCount == COUNT_W'(LAST_BIT));

  always_comb begin
    if (!rstN) begin
      p_reset_quiet_r1: assert (!txIrq && !rxIrq && !dmaReq && !rxLoad);
    end
  end

  p_load_on_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
    (sclRise && onLast) |=> rxLoad);

  p_ack_rx_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!modeSel && sclRise && onLast && !sdaIn) |=> (rxIrq && !txIrq));

  p_nack_tx_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!modeSel && sclRise && onLast && sdaIn) |=> (txIrq && !rxIrq));

  p_edge_tx_r5: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel && sclRise && onLast) |=> (txIrq && !rxIrq));

  p_edge_rx_r6: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel && sclFall && !sclRise && onLast) |=> (rxIrq && !txIrq && !rxLoad));

  p_dma_tracks_rx_r7: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq == rxIrq);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !onLast |=> (!txIrq && !rxIrq && !rxLoad));

  p_ack_fall_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!modeSel && sclFall && !sclRise && onLast) |=> (!txIrq && !rxIrq && !rxLoad));
endmodule

bind i2cByteEvents i2cByteEventsChk #(.DATA_BITS(DATA_BITS), .COUNT_W(COUNT_W)) uChk (
  .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
  .bitCount(bitCount), .sdaIn(sdaIn), .modeSel(modeSel),
  .txIrq(txIrq), .rxIrq(rxIrq), .dmaReq(dmaReq), .rxLoad(rxLoad)
);

// File: tb/i2cByteEvents_test.sv
module i2cByteEvents_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclRise = 1'b0, sclFall = 1'b0, sdaIn = 1'b1, modeSel = 1'b0;
  logic [3:0] bitCount = 4'd0;
  logic txIrq, rxIrq, dmaReq, rxLoad;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  i2cByteEvents uut (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .bitCount(bitCount), .sdaIn(sdaIn), .modeSel(modeSel),
    .txIrq(txIrq), .rxIrq(rxIrq), .dmaReq(dmaReq), .rxLoad(rxLoad)
  );

  function automatic logic [3:0] expect4(input logic m, input logic r, input logic f,
                                         input logic [3:0] bc, input logic s);
    logic last, tx, rx, ld;
    last = (bc == 4'd9);
    ld = last && r;
    if (m) begin
      tx = last && r;
      rx = last && f;
    end else begin
      tx = last && r && s;
      rx = last && r && !s;
    end
    return {tx, rx, rx, ld};
  endfunction

  task automatic check(input string tag, input string name, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", tag, name, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic r, input logic f,
                      input logic [3:0] bc, input logic s, input string tagOver);
    logic [3:0] e;
    @(negedge clk);
    modeSel = m; sclRise = r; sclFall = f; bitCount = bc; sdaIn = s;
    e = expect4(m, r, f, bc, s);
    @(posedge clk);
    #2;
    check(tagOver != "" ? tagOver : (bc != 4'd9 ? "R8" : (m ? "R5" : "R4")), "txIrq", txIrq, e[3]);
    check(tagOver != "" ? tagOver : (bc != 4'd9 ? "R8" : (m ? "R6" : "R3")), "rxIrq", rxIrq, e[2]);
    check("R7", "dmaReq", dmaReq, e[1]);
    check(tagOver != "" ? tagOver : (bc != 4'd9 ? "R8" : "R2"), "rxLoad", rxLoad, e[0]);
  endtask

  initial begin
    void'($urandom(32'd1234));
    #5;
    check("R1", "txIrq", txIrq, 1'b0);
    check("R1", "rxIrq", rxIrq, 1'b0);
    check("R1", "dmaReq", dmaReq, 1'b0);
    check("R1", "rxLoad", rxLoad, 1'b0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #2;
    check("R1", "all", txIrq | rxIrq | dmaReq | rxLoad, 1'b0);

    step(1'b0, 1'b1, 1'b0, 4'd9, 1'b0, "R3");
    step(1'b0, 1'b0, 1'b0, 4'd9, 1'b0, "R2");
    step(1'b0, 1'b1, 1'b0, 4'd9, 1'b1, "R4");
    step(1'b0, 1'b0, 1'b1, 4'd9, 1'b0, "R9");
    step(1'b1, 1'b1, 1'b0, 4'd9, 1'b1, "R5");
    step(1'b1, 1'b1, 1'b0, 4'd9, 1'b0, "R5");
    step(1'b1, 1'b0, 1'b1, 4'd9, 1'b0, "R6");
    step(1'b1, 1'b1, 1'b0, 4'd8, 1'b0, "R8");
    step(1'b0, 1'b1, 1'b0, 4'd0, 1'b0, "R8");
    step(1'b0, 1'b1, 1'b0, 4'd9, 1'b0, "R2");
    step(1'b1, 1'b0, 1'b1, 4'd9, 1'b0, "R6");

    for (int i = 0; i < 3000; i++) begin
      int kind;
      logic [3:0] bc;
      kind = $urandom_range(0, 2);
      bc = ($urandom_range(0, 1) == 0) ? 4'd9 : 4'($urandom_range(0, 9));
      step(1'($urandom_range(0, 1)), kind == 1, kind == 2, bc,
           1'($urandom_range(0, 1)), "");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule